// File: doc/BRIEF.md
# Run-Length Sample Compressor

This block sits in the capture path of an on-chip signal probe, between the sampled signals and the capture store. It does not write every clock's sample. It keeps the value it saw last and counts how many enabled cycles in a row carried that same value. It emits one packed record only when the run ends. A run ends in one of three ways: the input changes, the counter can no longer grow, or a flush request closes it at the end of a capture. The same number of storage words therefore covers a much longer stretch of quiet signal activity.

Each record is one word. The run length sits in the upper field and the sample value in the lower field. Both widths are parameters and must be multiples of 8, so a record is always a whole number of bytes. The counter defaults to 16 bits. A counter that fills up does not wrap. The block closes the run at the largest count and opens a fresh run for the same value. The sample enable lets the capture controller pause the block. A paused cycle neither adds to nor disturbs the pending run.

Top module: `rlc_compressor`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rec_valid` is low and `rec_word` is zero. After reset no run is pending.
- R2: When no run is pending, an enabled sample opens a run with a count of 1 and that sample's value. No record is produced.
- R3: An enabled sample equal to the held value adds one to the pending count and produces no record, as long as the count is below its maximum.
- R4: An enabled sample that differs from the held value makes `rec_valid` high for exactly the next cycle. The record carries the old value and its count, and a new run opens with the new value and a count of 1.
- R5: Record layout: bits [CNT_W+DATA_W-1:DATA_W] hold the run count and bits [DATA_W-1:0] hold the sample value. The count is never zero.
- R6: If the count already equals 2^CNT_W-1 and another identical enabled sample arrives, a record with the all-ones count is emitted. That sample then opens a new run for the same value with a count of 1.
- R7: While `sample_en` is low and `flush` is low, `sample_in` is ignored, the held value and count stay unchanged, and no record is emitted.
- R8: `flush` with a run pending emits that run on the next cycle whether or not the data changed. If `sample_en` is low in that cycle, no run remains pending. If it is high, that cycle's sample opens a new run with a count of 1.
- R9: `flush` with no run pending emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Take `sample_in` this cycle |
| sample_in | input | DATA_W | Probed signal value |
| flush | input | 1 | Close and emit the pending run |
| rec_valid | output | 1 | One-cycle strobe: `rec_word` holds a record |
| rec_word | output | CNT_W+DATA_W | Packed record {count, value} |

## Verification
The hardest case to reach from the ports is counter saturation. It needs an unbroken run of 2^CNT_W-1 identical enabled samples before the closing sample arrives. The bench builds the block with an 8-bit count field and holds one value for 255 enabled cycles. It then supplies the 256th sample and expects an all-ones record. Two more samples of the same value and then a different value follow, which shows that the saturating sample opened a new run with a count of 1. Flush arriving in the same cycle as an enabled sample is driven on purpose, so that both the emitted count and the count of the following run can be checked.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  localparam int DEF_DATA_W = 16;
  localparam int DEF_CNT_W  = 16;

  // A field width is legal when it is a positive whole number of bytes.
  function automatic bit width_ok(input int w);
    return (w > 0) && ((w % 8) == 0);
  endfunction

endpackage

// File: rtl/rlc_change_detect.sv
module rlc_change_detect #(
  parameter int DATA_W = rlc_pkg::DEF_DATA_W,
  parameter int CNT_W  = rlc_pkg::DEF_CNT_W
) (
  input  logic              live,
  input  logic              en,
  input  logic              flush,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] held,
  input  logic [CNT_W-1:0]  cnt,
  output logic              diff,
  output logic              at_max,
  output logic              emit,
  output logic              start,
  output logic              bump
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic is_full(input logic [CNT_W-1:0] c);
    return c == CNT_MAX;
  endfunction

  always_comb begin
    diff   = live && en && (din != held);
    at_max = live && en && (din == held) && is_full(cnt);
    emit   = live && (flush || diff || at_max);
    start  = en && (emit || !live);
    bump   = en && live && !emit;
  end

endmodule

// File: rtl/rlc_run_state.sv
module rlc_run_state #(
  parameter int DATA_W = rlc_pkg::DEF_DATA_W,
  parameter int CNT_W  = rlc_pkg::DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  input  logic              emit,
  input  logic              start,
  input  logic              bump,
  output logic              live,
  output logic [DATA_W-1:0] held,
  output logic [CNT_W-1:0]  cnt
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + CNT_ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0;
      held <= '0;
      cnt  <= '0;
    end else if (start) begin
      live <= 1'b1;
      held <= din;
      cnt  <= CNT_ONE;
    end else if (bump) begin
      cnt  <= step(cnt);
    end else if (emit && !en) begin
      live <= 1'b0;
    end
  end

endmodule

// File: rtl/rlc_record_out.sv
module rlc_record_out #(
  parameter int DATA_W = rlc_pkg::DEF_DATA_W,
  parameter int CNT_W  = rlc_pkg::DEF_CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    emit,
  input  logic [DATA_W-1:0]       held,
  input  logic [CNT_W-1:0]        cnt,
  output logic                    rec_valid,
  output logic [CNT_W+DATA_W-1:0] rec_word
);

  function automatic logic [CNT_W+DATA_W-1:0] pack(
    input logic [CNT_W-1:0] c, input logic [DATA_W-1:0] d);
    return {c, d};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_word  <= '0;
    end else begin
      rec_valid <= emit;
      if (emit) rec_word <= pack(cnt, held);
    end
  end

endmodule

// File: rtl/rlc_compressor.sv
module rlc_compressor #(
  parameter int DATA_W = rlc_pkg::DEF_DATA_W,
  parameter int CNT_W  = rlc_pkg::DEF_CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_en,
  input  logic [DATA_W-1:0]       sample_in,
  input  logic                    flush,
  output logic                    rec_valid,
  output logic [CNT_W+DATA_W-1:0] rec_word
);

  generate
    if (!rlc_pkg::width_ok(DATA_W) || !rlc_pkg::width_ok(CNT_W)) begin : g_bad_width
      initial $fatal(1, "rlc_compressor: DATA_W and CNT_W must be multiples of 8");
    end
  endgenerate

  logic              live;
  logic [DATA_W-1:0] held;
  logic [CNT_W-1:0]  cnt;
  logic              ev_diff;
  logic              ev_full;
  logic              ev_emit;
  logic              ev_start;
  logic              ev_bump;

  rlc_change_detect #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_detect (
    .live   (live),
    .en     (sample_en),
    .flush  (flush),
    .din    (sample_in),
    .held   (held),
    .cnt    (cnt),
    .diff   (ev_diff),
    .at_max (ev_full),
    .emit   (ev_emit),
    .start  (ev_start),
    .bump   (ev_bump)
  );

  rlc_run_state #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sample_en),
    .din   (sample_in),
    .emit  (ev_emit),
    .start (ev_start),
    .bump  (ev_bump),
    .live  (live),
    .held  (held),
    .cnt   (cnt)
  );

  rlc_record_out #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (ev_emit),
    .held      (held),
    .cnt       (cnt),
    .rec_valid (rec_valid),
    .rec_word  (rec_word)
  );

endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int DATA_W = rlc_pkg::DEF_DATA_W,
  parameter int CNT_W  = rlc_pkg::DEF_CNT_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_en,
  input logic [DATA_W-1:0]       sample_in,
  input logic                    flush,
  input logic                    rec_valid,
  input logic [CNT_W+DATA_W-1:0] rec_word,
  input logic                    live,
  input logic [DATA_W-1:0]       held,
  input logic [CNT_W-1:0]        cnt
);

  localparam int TOP = CNT_W + DATA_W - 1;

  a_r2_open_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && sample_en && !flush) |=> !rec_valid);

  a_r3_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_word[TOP:DATA_W] != '0));

  a_r4_change_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sample_en && (sample_in != held)) |=>
      (rec_valid && rec_word[DATA_W-1:0] == $past(held)
                 && rec_word[TOP:DATA_W] == $past(cnt)));

  a_r6_full_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sample_en && (sample_in == held) && (&cnt)) |=>
      (rec_valid && (&rec_word[TOP:DATA_W]) && cnt == CNT_W'(1)));

  a_r7_paused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !flush) |=> (!rec_valid && $stable(cnt) && $stable(held)));

  a_r8_flush_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (live && flush) |=> rec_valid);

  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && flush) |=> !rec_valid);

endmodule

bind rlc_compressor rlc_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rlc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_en (sample_en),
  .sample_in (sample_in),
  .flush     (flush),
  .rec_valid (rec_valid),
  .rec_word  (rec_word),
  .live      (live),
  .held      (held),
  .cnt       (cnt)
);

// File: tb/test_rlc_compressor.sv
module test_rlc_compressor;

  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_en = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic          flush = 1'b0;
  logic          rec_valid;
  logic [CW+DW-1:0] rec_word;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rlc_compressor #(.DATA_W(DW), .CNT_W(CW)) i_rlc_compressor (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_in(sample_in),
    .flush(flush), .rec_valid(rec_valid), .rec_word(rec_word)
  );

  // Drive one cycle at the falling edge, then look just after the rising edge.
  task automatic cyc(input logic e, input logic [DW-1:0] d, input logic f);
    @(negedge clk);
    sample_en = e; sample_in = d; flush = f;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_none(input string req);
    n_run++;
    if (rec_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: rec_valid=%b expected 0", req, rec_valid);
    end
  endtask

  task automatic expect_rec(input string req, input int c, input logic [DW-1:0] d);
    logic [CW+DW-1:0] want;
    want = {CW'(c), d};
    n_run++;
    if (rec_valid !== 1'b1 || rec_word !== want) begin
      n_fail++;
      $display("FAIL %s: valid=%b word=%h expected valid=1 word=%h", req, rec_valid, rec_word, want);
    end
  endtask

  task automatic t_reset;
    n_run++;
    if (rec_valid !== 1'b0 || rec_word !== '0) begin
      n_fail++;
      $display("FAIL R1: valid=%b word=%h expected 0/0", rec_valid, rec_word);
    end
    cyc(1'b0, 16'h1111, 1'b1);
    expect_none("R1/R9 flush after reset");
  endtask

  task automatic t_basic;
    cyc(1'b1, 16'hA5A5, 1'b0); expect_none("R2 first sample");
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 16'hA5A5, 1'b0); expect_none("R3 repeat");
    end
    cyc(1'b1, 16'h1234, 1'b0); expect_rec("R4/R5 change", 4, 16'hA5A5);
    cyc(1'b1, 16'h1234, 1'b0); expect_none("R4 single pulse");
    cyc(1'b0, 16'h9999, 1'b1); expect_rec("R8 flush paused", 2, 16'h1234);
    cyc(1'b0, 16'h9999, 1'b1); expect_none("R9 flush empty");
  endtask

  task automatic t_alternate;
    cyc(1'b1, 16'h0001, 1'b0); expect_none("R2 open");
    for (int i = 2; i < 6; i++) begin
      cyc(1'b1, DW'(i), 1'b0); expect_rec("R4 alternating", 1, DW'(i - 1));
    end
    cyc(1'b0, 16'h0000, 1'b1); expect_rec("R8 flush tail", 1, 16'h0005);
  endtask

  task automatic t_pause;
    cyc(1'b1, 16'h0F0F, 1'b0);
    cyc(1'b1, 16'h0F0F, 1'b0);
    cyc(1'b1, 16'h0F0F, 1'b0); expect_none("R3 count");
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, DW'(16'h5000 + i), 1'b0); expect_none("R7 paused input ignored");
    end
    cyc(1'b1, 16'h0F0F, 1'b0); expect_none("R7 resume");
    cyc(1'b1, 16'h7777, 1'b0); expect_rec("R7 count held over pause", 4, 16'h0F0F);
    cyc(1'b0, 16'h0000, 1'b1); expect_rec("R8 flush", 1, 16'h7777);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 255; i++) begin
      cyc(1'b1, 16'h00FF, 1'b0);
      if (i == 0 || i == 254) expect_none("R3 long run");
    end
    cyc(1'b1, 16'h00FF, 1'b0); expect_rec("R6 saturation", 255, 16'h00FF);
    cyc(1'b1, 16'h00FF, 1'b0); expect_none("R6 after saturation");
    cyc(1'b1, 16'h00FF, 1'b0);
    cyc(1'b1, 16'hC3C3, 1'b0); expect_rec("R6 restart at 1", 3, 16'h00FF);
    cyc(1'b0, 16'h0000, 1'b1); expect_rec("R8 flush", 1, 16'hC3C3);
  endtask

  task automatic t_flush_enabled;
    cyc(1'b1, 16'hBEEF, 1'b0);
    cyc(1'b1, 16'hBEEF, 1'b0);
    cyc(1'b1, 16'hBEEF, 1'b1); expect_rec("R8 flush same data", 2, 16'hBEEF);
    cyc(1'b1, 16'hCAFE, 1'b0); expect_rec("R8 flush sample opens run", 1, 16'hBEEF);
    cyc(1'b0, 16'h0000, 1'b1); expect_rec("R8 flush", 1, 16'hCAFE);
    cyc(1'b0, 16'h0000, 1'b0); expect_none("R9 idle");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_hold();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset;
    t_basic;
    t_alternate;
    t_pause;
    t_saturate;
    t_flush_enabled;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic t_reset_hold;
    n_run++;
    if (rec_valid !== 1'b0 || rec_word !== '0) begin
      n_fail++;
      $display("FAIL R1: in reset valid=%b word=%h expected 0/0", rec_valid, rec_word);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule